// File: doc/BRIEF.md
# Big-Endian Load/Store Unit

This block sits between a 32-bit register datapath and a byte-addressed, word-wide synchronous memory. Each request carries a base register value, a signed 16-bit immediate offset, an operation code and, for stores, a data register. The unit adds the base and the sign-extended offset to form the effective address. It then drives one registered access on the memory port: a word address, byte enables, write data, a write strobe and a read strobe.

Bytes inside a memory word are numbered big-endian. The byte at word offset 0 occupies bits 31:24 and the byte at offset 3 occupies bits 7:0. Loads pick the addressed byte, halfword or word out of the returned word and extend it to 32 bits. The result comes back with a one-cycle valid pulse. A new request may be presented on every cycle, and requests complete in issue order.

Operation codes on `req_op`: 0 unsigned byte load, 1 signed byte load, 2 unsigned halfword load, 3 word load, 4 byte store, 5 word store. Codes 6 and 7 are unused.

Top module: `be_lsu`

## Requirements
- R1: The effective address is `req_base` plus `req_offset` sign-extended to 32 bits. For a memory access, `mem_addr` carries the effective address with its two low bits dropped. For example, a base of 0x0FC with offset 4 gives word address 0x40, which is byte 0x100.
- R2: Op 0 returns the addressed byte zero-extended. The byte at offset o comes from bits 31-8o down to 24-8o of the memory word, so a byte holding 0xAB reads as 0x000000AB.
- R3: Op 1 returns the addressed byte sign-extended, so 0xFF reads as 0xFFFFFFFF.
- R4: Op 2 uses address bit 1 to pick a half of the word: 0 picks bits 31:16 and 1 picks bits 15:0. The half is zero-extended and address bit 0 is ignored. After word 0x12345678 is stored at 0x100, this op at 0x100 returns 0x00001234.
- R5: Op 3 returns the whole memory word unchanged, whatever the two low address bits are.
- R6: Op 4 asserts `mem_we` with exactly one byte enable: `mem_be` = 4'b1000 shifted right by address bits 1:0. The enabled lane of `mem_wdata` holds the low 8 bits of `req_sdata`, so the other bytes of the word keep their contents.
- R7: Op 5 asserts `mem_we` with `mem_be` = 4'b1111 and `mem_wdata` = `req_sdata`, whatever the two low address bits are.
- R8: A load raises `mem_re` one cycle after the request. `load_valid` rises three cycles after the request, stays high for one cycle per load, and `load_data` is valid in that cycle.
- R9: When `req_valid` is low, or the op is 6 or 7, the unit makes no memory access and produces no load result.
- R10: While `rst` is high, `mem_we`, `mem_re`, `mem_be`, `load_valid` and `load_data` are all zero.
- R11: Requests issued on consecutive cycles are each serviced in order. A load issued on the cycle right after a store to the same address returns the newly stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_base | input | 32 | Base register value |
| req_offset | input | 16 | Signed immediate offset |
| req_sdata | input | 32 | Store data register |
| mem_addr | output | 30 | Word address to memory |
| mem_be | output | 4 | Byte enables, bit 3 = bits 31:24 |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, registered by memory one cycle after `mem_re` |
| load_data | output | 32 | Extended load result |
| load_valid | output | 1 | Load result valid pulse |

## Verification
Two things can land in the same cycle. An earlier load can return its result through `load_valid` while the memory port is busy with a later store or load. A store and a load of the same byte can also be issued back to back, so the load's read follows the write by a single cycle. The sweep provokes both. It issues every op code at every byte offset with no idle cycles, and it follows each store at once with a word load of the same address. Each load result is compared, in the exact cycle it must appear, with a value taken from a byte-wise big-endian shadow memory that the bench updates in program order.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  typedef enum logic [2:0] {
    OP_LDBU = 3'd0,
    OP_LDB  = 3'd1,
    OP_LDHU = 3'd2,
    OP_LDW  = 3'd3,
    OP_STB  = 3'd4,
    OP_STW  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } lsu_op_e;
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] base,
  input  logic [IMM_W-1:0]  offset,
  output logic [DATA_W-1:0] ea
);
  localparam int EXT_W = DATA_W - IMM_W;

  assign ea = base + {{EXT_W{offset[IMM_W-1]}}, offset};
endmodule

// File: rtl/lsu_store_fmt.sv
module lsu_store_fmt
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  lsu_op_e                op,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [DATA_W-1:0]      sdata,
  output logic [DATA_W/8-1:0]    be,
  output logic [DATA_W-1:0]      wdata
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic is_sb, is_sw;
  assign is_sb = (op == OP_STB);
  assign is_sw = (op == OP_STW);

  // big-endian: byte offset o lives in lane LANES-1-o
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign be[l] = is_sw | (is_sb & (off == OFF_W'(LANES - 1 - l)));
    assign wdata[8*l +: 8] = is_sw ? sdata[8*l +: 8] : sdata[7:0];
  end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   vld_in,
  input  lsu_op_e                op,
  input  logic [$clog2(DATA_W/8)-1:0] off,
  input  logic [DATA_W-1:0]      rdata,
  output logic [DATA_W-1:0]      data_q,
  output logic                   vld_q
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  logic [7:0]        bsel;
  logic [15:0]       hsel;
  logic [OFF_W-1:0]  hoff;
  logic [DATA_W-1:0] ext;

  assign hoff = {off[OFF_W-1:1], 1'b0};

  always_comb begin
    bsel = '0;
    for (int l = 0; l < LANES; l++) begin
      if (off == OFF_W'(LANES - 1 - l)) bsel = rdata[8*l +: 8];
    end
  end

  always_comb begin
    hsel = '0;
    for (int l = 1; l < LANES; l++) begin
      if (hoff == OFF_W'(LANES - 1 - l)) hsel = rdata[8*(l-1) +: 16];
    end
  end

  always_comb begin
    case (op)
      OP_LDBU: ext = {{(DATA_W-8){1'b0}}, bsel};
      OP_LDB:  ext = {{(DATA_W-8){bsel[7]}}, bsel};
      OP_LDHU: ext = {{(DATA_W-16){1'b0}}, hsel};
      OP_LDW:  ext = rdata;
      default: ext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      vld_q  <= vld_in;
      data_q <= vld_in ? ext : '0;
    end
  end
endmodule

// File: rtl/be_lsu.sv
module be_lsu
  import lsu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic [2:0]                   req_op,
  input  logic [DATA_W-1:0]            req_base,
  input  logic [IMM_W-1:0]             req_offset,
  input  logic [DATA_W-1:0]            req_sdata,
  output logic [DATA_W-$clog2(DATA_W/8)-1:0] mem_addr,
  output logic [DATA_W/8-1:0]          mem_be,
  output logic                         mem_we,
  output logic                         mem_re,
  output logic [DATA_W-1:0]            mem_wdata,
  input  logic [DATA_W-1:0]            mem_rdata,
  output logic [DATA_W-1:0]            load_data,
  output logic                         load_valid
);
  localparam int LANES = DATA_W / 8;
  localparam int OFF_W = $clog2(LANES);

  lsu_op_e             op_in;
  logic [DATA_W-1:0]   ea;
  logic                is_ld, is_st;
  logic [LANES-1:0]    be_c;
  logic [DATA_W-1:0]   wd_c;

  lsu_op_e             t1_op, t2_op;
  logic [OFF_W-1:0]    t1_off, t2_off;
  logic                t2_vld;

  assign op_in = lsu_op_e'(req_op);
  assign is_ld = req_valid && (op_in inside {OP_LDBU, OP_LDB, OP_LDHU, OP_LDW});
  assign is_st = req_valid && (op_in inside {OP_STB, OP_STW});

  lsu_agen #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_agen (
    .base   (req_base),
    .offset (req_offset),
    .ea     (ea)
  );

  lsu_store_fmt #(.DATA_W(DATA_W)) u_stfmt (
    .op    (op_in),
    .off   (ea[OFF_W-1:0]),
    .sdata (req_sdata),
    .be    (be_c),
    .wdata (wd_c)
  );

  // stage 1: memory port; stage 2: wait for registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_we    <= 1'b0;
      mem_re    <= 1'b0;
      mem_wdata <= '0;
      t1_op     <= OP_LDBU;
      t1_off    <= '0;
      t2_vld    <= 1'b0;
      t2_op     <= OP_LDBU;
      t2_off    <= '0;
    end else begin
      mem_addr  <= ea[DATA_W-1:OFF_W];
      mem_be    <= is_st ? be_c : '0;
      mem_we    <= is_st;
      mem_re    <= is_ld;
      mem_wdata <= wd_c;
      t1_op     <= op_in;
      t1_off    <= ea[OFF_W-1:0];
      t2_vld    <= mem_re;
      t2_op     <= t1_op;
      t2_off    <= t1_off;
    end
  end

  lsu_load_fmt #(.DATA_W(DATA_W)) u_ldfmt (
    .clk    (clk),
    .rst    (rst),
    .vld_in (t2_vld),
    .op     (t2_op),
    .off    (t2_off),
    .rdata  (mem_rdata),
    .data_q (load_data),
    .vld_q  (load_valid)
  );
endmodule

// File: rtl/be_lsu_chk.sv
module be_lsu_chk #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         req_valid,
  input logic [2:0]                   req_op,
  input logic [DATA_W-1:0]            req_base,
  input logic [IMM_W-1:0]             req_offset,
  input logic [DATA_W-$clog2(DATA_W/8)-1:0] mem_addr,
  input logic [DATA_W/8-1:0]          mem_be,
  input logic                         mem_we,
  input logic                         mem_re,
  input logic                         load_valid
);
  localparam int OFF_W = $clog2(DATA_W/8);

  logic [DATA_W-1:0] ea_ref;
  assign ea_ref = req_base + {{(DATA_W-IMM_W){req_offset[IMM_W-1]}}, req_offset};

  p_addr_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op < 3'd6) |=> (mem_addr == $past(ea_ref[DATA_W-1:OFF_W])));

  p_load_issue_r8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_op[2]) |=> (mem_re && !mem_we));

  p_byte_store_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd4) |=> (mem_we && $countones(mem_be) == 1));

  p_word_store_r7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_op == 3'd5) |=> (mem_we && &mem_be));

  p_no_access_r9: assert property (@(posedge clk) disable iff (rst)
    (!req_valid || req_op[2:1] == 2'b11) |=> (!mem_we && !mem_re));

  p_result_lat_r8: assert property (@(posedge clk) disable iff (rst)
    load_valid |-> $past(mem_re, 2));
endmodule

bind be_lsu be_lsu_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .req_base   (req_base),
  .req_offset (req_offset),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .load_valid (load_valid)
);

// File: tb/tb_be_lsu.sv
module tb_be_lsu;
  localparam int WORDS = 1024;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst, req_valid;
  logic [2:0]  req_op;
  logic [31:0] req_base, req_sdata;
  logic [15:0] req_offset;
  logic [29:0] mem_addr;
  logic [3:0]  mem_be;
  logic        mem_we, mem_re;
  logic [31:0] mem_wdata, mem_rdata, load_data;
  logic        load_valid;

  be_lsu dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_base(req_base), .req_offset(req_offset), .req_sdata(req_sdata),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .load_data(load_data), .load_valid(load_valid)
  );

  logic [31:0] mem [WORDS];
  logic [7:0]  shadow [4*WORDS];

  always @(posedge clk) begin
    if (mem_we)
      for (int b = 0; b < 4; b++)
        if (mem_be[b]) mem[mem_addr[9:0]][8*b +: 8] <= mem_wdata[8*b +: 8];
    if (mem_re) mem_rdata <= mem[mem_addr[9:0]];
  end

  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;
  int    due_q[$];
  logic [31:0] val_q[$];
  string tag_q[$];

  int          p_kind;   // 0 none, 1 load, 2 byte store, 3 word store
  logic [31:0] p_ea, p_sd;
  string       p_tag;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  function automatic logic [31:0] ld_exp(input logic [2:0] op, input logic [31:0] ea);
    logic [11:0] a, h, w;
    a = ea[11:0];
    h = {a[11:1], 1'b0};
    w = {a[11:2], 2'b00};
    case (op)
      3'd0: return {24'h0, shadow[a]};
      3'd1: return {{24{shadow[a][7]}}, shadow[a]};
      3'd2: return {16'h0, shadow[h], shadow[h + 12'd1]};
      default: return {shadow[w], shadow[w + 12'd1], shadow[w + 12'd2], shadow[w + 12'd3]};
    endcase
  endfunction

  task automatic step(input logic v, input logic [2:0] op, input logic [31:0] b,
                      input logic [15:0] off, input logic [31:0] sd);
    logic [31:0] ea;
    logic [3:0]  bm;
    logic [31:0] lm;
    bit          expv;
    @(negedge clk);
    cyc++;
    // memory port for the previous request
    case (p_kind)
      0: chk(!mem_we && !mem_re, p_tag, {30'h0, mem_we, mem_re}, 32'h0);
      1: begin
        chk(mem_re && !mem_we, "R8", {30'h0, mem_we, mem_re}, 32'h1);
        chk(mem_addr == p_ea[31:2], "R1", {2'b0, mem_addr}, {2'b0, p_ea[31:2]});
      end
      2: begin
        bm = 4'b1000 >> p_ea[1:0];
        lm = {{8{bm[3]}}, {8{bm[2]}}, {8{bm[1]}}, {8{bm[0]}}};
        chk(mem_we && !mem_re, "R6", {30'h0, mem_we, mem_re}, 32'h2);
        chk(mem_be == bm, "R6", {28'h0, mem_be}, {28'h0, bm});
        chk((mem_wdata & lm) == ({4{p_sd[7:0]}} & lm), "R6", mem_wdata & lm, {4{p_sd[7:0]}} & lm);
        chk(mem_addr == p_ea[31:2], "R1", {2'b0, mem_addr}, {2'b0, p_ea[31:2]});
      end
      default: begin
        chk(mem_we && !mem_re && mem_be == 4'hF, "R7", {27'h0, mem_be, mem_we}, 32'h1F);
        chk(mem_wdata == p_sd, "R7", mem_wdata, p_sd);
        chk(mem_addr == p_ea[31:2], "R1", {2'b0, mem_addr}, {2'b0, p_ea[31:2]});
      end
    endcase
    // load result stream
    expv = (due_q.size() > 0) && (due_q[0] == cyc);
    chk(load_valid == expv, "R8", {31'h0, load_valid}, {31'h0, expv});
    if (expv) begin
      chk(load_data == val_q[0], tag_q[0], load_data, val_q[0]);
      void'(due_q.pop_front());
      void'(val_q.pop_front());
      void'(tag_q.pop_front());
    end
    // drive the new request
    req_valid  = v;
    req_op     = op;
    req_base   = b;
    req_offset = off;
    req_sdata  = sd;
    ea = b + {{16{off[15]}}, off};
    p_ea = ea;
    p_sd = sd;
    p_kind = 0;
    p_tag = "R9";
    if (v) begin
      if (op <= 3'd3) begin
        p_kind = 1;
        due_q.push_back(cyc + 3);
        val_q.push_back(ld_exp(op, ea));
        case (op)
          3'd0: tag_q.push_back("R2");
          3'd1: tag_q.push_back("R3");
          3'd2: tag_q.push_back("R4");
          default: tag_q.push_back("R5");
        endcase
      end else if (op == 3'd4) begin
        p_kind = 2;
        shadow[ea[11:0]] = sd[7:0];
      end else if (op == 3'd5) begin
        p_kind = 3;
        for (int i = 0; i < 4; i++)
          shadow[{ea[11:2], 2'(i)}] = sd[31-8*i -: 8];
      end
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] ea, bs, sd;
    logic [15:0] off;
    for (int w = 0; w < WORDS; w++) begin
      mem[w] = 32'h9E37_79B9 * w + 32'h0135_7BDF;
      for (int i = 0; i < 4; i++) shadow[4*w + i] = mem[w][31-8*i -: 8];
    end
    rst = 1'b1; req_valid = 1'b0; req_op = '0; req_base = '0; req_offset = '0; req_sdata = '0;
    p_kind = 0; p_tag = "R9"; p_ea = '0; p_sd = '0;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(!mem_we && !mem_re && mem_be == 4'h0, "R10", {27'h0, mem_be, mem_we}, 32'h0);
    chk(!load_valid && load_data == 32'h0, "R10", load_data, 32'h0);
    rst = 1'b0;

    // worked examples (R1, R2, R3, R4, R5, R6, R7)
    step(1, 3'd5, 32'h0FC, 16'd4, 32'h1234_5678);
    step(1, 3'd2, 32'h100, 16'd0, 32'h0);
    step(1, 3'd3, 32'h100, 16'd0, 32'h0);
    step(1, 3'd2, 32'h104, 16'hFFFE, 32'h0);
    step(1, 3'd4, 32'h108, 16'hFFFC, 32'hCDEF_01AB);
    step(1, 3'd0, 32'h0FC, 16'd8, 32'h0);
    step(1, 3'd3, 32'h104, 16'd0, 32'h0);
    step(1, 3'd4, 32'h107, 16'd0, 32'h0000_00FF);
    step(1, 3'd1, 32'h107, 16'd0, 32'h0);
    step(1, 3'd0, 32'h107, 16'd0, 32'h0);
    for (int i = 0; i < 5; i++) step(0, 3'd3, 32'h100, 16'd0, 32'h0);

    // R11: back-to-back sweep of every op at every byte offset
    for (int op = 0; op < 8; op++) begin
      for (int k = 0; k < 32; k++) begin
        ea  = 32'h200 + k;
        off = 16'(k * 613 - 9000);
        bs  = ea - {{16{off[15]}}, off};
        sd  = 32'hA500_0000 ^ (32'h0101_0101 * k) ^ (op * 32'h0011_0077);
        step(1, 3'(op), bs, off, sd);
        if (op == 4 || op == 5) step(1, 3'd3, ea, 16'd0, 32'h0);
        if (k % 5 == 0) step(0, 3'(op), bs, off, sd);
      end
    end
    for (int i = 0; i < 6; i++) step(0, 3'd0, 32'h0, 16'd0, 32'h0);
    chk(due_q.size() == 0, "R8", due_q.size(), 32'h0);

    done = 1;
    summary();
    $finish;
  end
endmodule